// File: doc/BRIEF.md
# I2C Byte-Completion Status Controller

This block works next to an I2C shift engine. It updates the control and status flags each time an address byte or a data byte finishes. The engine gives it a one-cycle strobe on the falling edge of the acknowledge clock, along with what it has decoded from the byte:

- whether the byte is a slave address,
- whether that address matched,
- whether it was the general-call address,
- the read/write bit,
- the sampled acknowledge level.

The block drives the following:

- an active-low pending flag,
- an interrupt request,
- a bit counter,
- the master and transmit-direction flags,
- a general-call flag,
- an addressed-as-slave flag,
- an SCL hold request, asserted while an event waits for software.

Some results depend on the acknowledge strobe. Software owns others through a write strobe. After a matched address, a small sequencer counts pulses of the I2C clock enable `tick`, which occur after the strobe cycle. It uses them to place the general-call and direction updates. The sequencer has three states:

- `ST_IDLE`: nothing is scheduled.
- `ST_GC_WAIT`: the sequencer counts ticks up to `GC_DLY`. On reaching it, it raises the general-call flag if the general-call address was seen, then moves to `ST_DIR_WAIT`.
- `ST_DIR_WAIT`: the sequencer keeps counting up to `DIR_DLY`. On reaching it, it sets the direction flag if the read/write bit was 1, then returns to `ST_IDLE`.

A matched address strobe moves the sequencer from any state to `ST_GC_WAIT` and clears the count. Any other strobe moves it to `ST_IDLE`.

Top module: `i2c_bytedone_ctl`

## Requirements
- R1: An `ack_fall` strobe drives `pend_n` to 0 at that clock edge. `pend_n` returns to 1 only on an `sw_wr` with `sw_release`=1. If both happen in the same cycle, the strobe wins.
- R2: `irq` becomes 1 at the same edge that `pend_n` clears. It is cleared by `irq_ack` or `sw_irq_clr`. If a set and a clear happen in the same cycle, the set wins.
- R3: `scl_hold` is 1 exactly while `pend_n` is 0.
- R4: `bit_cnt` counts `bit_fall` strobes modulo 8. An `ack_fall` returns it to 000b, and this takes priority over a same-cycle `bit_fall`.
- R5: `arb_lost` clears `mst` at the next edge, overriding a same-cycle software write.
- R6: A data-byte strobe (`addr_phase`=0) with `mst`=0, `trx`=1 and `ack_level`=1 (no acknowledge) clears `trx`. With `ack_level`=0, or in any other mode, `trx` is kept.
- R7: An address strobe (`addr_phase`=1) sets `addr_hit` to (`own_match` OR `gcall_det`) and clears `gen_call`.
- R8: After a matched address strobe with `gcall_det`=1, `gen_call` rises at the edge that samples the first `tick` after the strobe cycle (`GC_DLY`=1).
- R9: After a matched address strobe with `rw_bit`=1, `trx` is set at the edge that samples the second `tick` (`DIR_DLY`=2). With `rw_bit`=0, or with no match, `trx` is not set.
- R10: When no hardware event touches them, `sw_wr` loads `mst` from `sw_mst` and `trx` from `sw_trx`.
- R11: A synchronous `rst` gives `pend_n`=1, `bit_cnt`=000b and all other flags 0.
- R12: A `tick` in the strobe cycle itself is not counted. A new strobe during a wait restarts the count using the new byte's values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | I2C clock enable, one pulse per I2C clock cycle |
| bit_fall | input | 1 | SCL falling edge of a data bit |
| ack_fall | input | 1 | SCL falling edge of the acknowledge clock |
| addr_phase | input | 1 | Finished byte was a slave address |
| own_match | input | 1 | Address equals own address |
| gcall_det | input | 1 | General-call address seen |
| rw_bit | input | 1 | Received read/write bit |
| ack_level | input | 1 | Sampled acknowledge level, 1 = not acknowledged |
| arb_lost | input | 1 | Arbitration lost |
| irq_ack | input | 1 | Interrupt accepted |
| sw_wr | input | 1 | Software write strobe |
| sw_release | input | 1 | Write value for pending flag release |
| sw_mst | input | 1 | Write value for master flag |
| sw_trx | input | 1 | Write value for direction flag |
| sw_irq_clr | input | 1 | Software clear of the interrupt request |
| pend_n | output | 1 | Pending flag, 0 = event requested |
| irq | output | 1 | Interrupt request |
| bit_cnt | output | 3 | Bit counter |
| mst | output | 1 | Master flag |
| trx | output | 1 | Transmit-direction flag |
| gen_call | output | 1 | General-call flag |
| addr_hit | output | 1 | Addressed-as-slave flag |
| scl_hold | output | 1 | Request to hold SCL low |

## Verification
The results triggered by the strobe (`pend_n`, `irq`, `bit_cnt`, `addr_hit`, the clearing of `trx`) and the software effects are all due one edge after the stimulus. `gen_call` is due at the edge that samples the first later `tick`, and the `trx` set at the edge of the second. The bench drives every input just after a rising edge and reads the outputs one step later. It inserts idle cycles without a `tick` between ticks, and checks after each of them that the delayed flags have not yet moved. Sweeps cover every combination of match, general call and read/write, and every combination of mode and acknowledge level.

// File: rtl/ibc_pkg.sv
package ibc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_GC_WAIT  = 2'd1,
        ST_DIR_WAIT = 2'd2
    } seq_state_t;
endpackage

// File: rtl/ibc_seq.sv
module ibc_seq #(
    parameter int GC_DLY  = 1,
    parameter int DIR_DLY = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic ack_fall,
    input  logic addr_phase,
    input  logic own_match,
    input  logic gcall_det,
    input  logic rw_bit,
    output logic gc_set,
    output logic dir_set
);
    import ibc_pkg::*;

    localparam int TW = $clog2(DIR_DLY + 1);
    localparam logic [TW-1:0] GC_CMP  = TW'(GC_DLY);
    localparam logic [TW-1:0] DIR_CMP = TW'(DIR_DLY);

    seq_state_t st, nxt;
    logic [TW-1:0] cnt, cnt_d, cnt_inc;
    logic gc_q, rw_q;
    logic hit;

    assign hit     = addr_phase && (own_match || gcall_det);
    assign cnt_inc = cnt + 1'b1;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_IDLE;
            cnt  <= '0;
            gc_q <= 1'b0;
            rw_q <= 1'b0;
        end else begin
            st  <= nxt;
            cnt <= cnt_d;
            if (ack_fall) begin
                gc_q <= gcall_det && addr_phase;
                rw_q <= rw_bit;
            end
        end
    end

    // next state
    always_comb begin
        nxt   = st;
        cnt_d = cnt;
        if (ack_fall) begin
            nxt   = hit ? ST_GC_WAIT : ST_IDLE;
            cnt_d = '0;
        end else if (tick) begin
            unique case (st)
                ST_IDLE:     nxt = ST_IDLE;
                ST_GC_WAIT: begin
                    cnt_d = cnt_inc;
                    if (cnt_inc == GC_CMP) nxt = ST_DIR_WAIT;
                end
                ST_DIR_WAIT: begin
                    cnt_d = cnt_inc;
                    if (cnt_inc == DIR_CMP) nxt = ST_IDLE;
                end
                default:     nxt = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        gc_set  = 1'b0;
        dir_set = 1'b0;
        if (!ack_fall && tick) begin
            unique case (st)
                ST_GC_WAIT:  gc_set  = gc_q && (cnt_inc == GC_CMP);
                ST_DIR_WAIT: dir_set = rw_q && (cnt_inc == DIR_CMP);
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/ibc_bitcnt.sv
module ibc_bitcnt #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_fall,
    input  logic             ack_fall,
    output logic [CNT_W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst || ack_fall) cnt <= '0;
        else if (bit_fall)   cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/ibc_flags.sv
module ibc_flags (
    input  logic clk,
    input  logic rst,
    input  logic ack_fall,
    input  logic addr_phase,
    input  logic own_match,
    input  logic gcall_det,
    input  logic ack_level,
    input  logic arb_lost,
    input  logic irq_ack,
    input  logic sw_wr,
    input  logic sw_release,
    input  logic sw_mst,
    input  logic sw_trx,
    input  logic sw_irq_clr,
    input  logic gc_set,
    input  logic dir_set,
    output logic pend_n,
    output logic irq,
    output logic mst,
    output logic trx,
    output logic gen_call,
    output logic addr_hit
);
    logic nak_drop;
    assign nak_drop = ack_fall && !addr_phase && !mst && trx && ack_level;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_n   <= 1'b1;
            irq      <= 1'b0;
            mst      <= 1'b0;
            trx      <= 1'b0;
            gen_call <= 1'b0;
            addr_hit <= 1'b0;
        end else begin
            if (ack_fall)                  pend_n <= 1'b0;
            else if (sw_wr && sw_release)  pend_n <= 1'b1;

            if (ack_fall)                  irq <= 1'b1;
            else if (irq_ack || sw_irq_clr) irq <= 1'b0;

            if (arb_lost)                  mst <= 1'b0;
            else if (sw_wr)                mst <= sw_mst;

            if (dir_set)                   trx <= 1'b1;
            else if (nak_drop)             trx <= 1'b0;
            else if (sw_wr)                trx <= sw_trx;

            if (ack_fall && addr_phase) begin
                addr_hit <= own_match || gcall_det;
                gen_call <= 1'b0;
            end else if (gc_set) begin
                gen_call <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/i2c_bytedone_ctl.sv
module i2c_bytedone_ctl #(
    parameter int CNT_W   = 3,
    parameter int GC_DLY  = 1,
    parameter int DIR_DLY = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             bit_fall,
    input  logic             ack_fall,
    input  logic             addr_phase,
    input  logic             own_match,
    input  logic             gcall_det,
    input  logic             rw_bit,
    input  logic             ack_level,
    input  logic             arb_lost,
    input  logic             irq_ack,
    input  logic             sw_wr,
    input  logic             sw_release,
    input  logic             sw_mst,
    input  logic             sw_trx,
    input  logic             sw_irq_clr,
    output logic             pend_n,
    output logic             irq,
    output logic [CNT_W-1:0] bit_cnt,
    output logic             mst,
    output logic             trx,
    output logic             gen_call,
    output logic             addr_hit,
    output logic             scl_hold
);
    logic gc_set, dir_set;

    ibc_seq #(.GC_DLY(GC_DLY), .DIR_DLY(DIR_DLY)) u_seq (
        .clk(clk), .rst(rst), .tick(tick), .ack_fall(ack_fall),
        .addr_phase(addr_phase), .own_match(own_match), .gcall_det(gcall_det),
        .rw_bit(rw_bit), .gc_set(gc_set), .dir_set(dir_set)
    );

    ibc_bitcnt #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .bit_fall(bit_fall), .ack_fall(ack_fall), .cnt(bit_cnt)
    );

    ibc_flags u_flags (
        .clk(clk), .rst(rst), .ack_fall(ack_fall), .addr_phase(addr_phase),
        .own_match(own_match), .gcall_det(gcall_det), .ack_level(ack_level),
        .arb_lost(arb_lost), .irq_ack(irq_ack), .sw_wr(sw_wr),
        .sw_release(sw_release), .sw_mst(sw_mst), .sw_trx(sw_trx),
        .sw_irq_clr(sw_irq_clr), .gc_set(gc_set), .dir_set(dir_set),
        .pend_n(pend_n), .irq(irq), .mst(mst), .trx(trx),
        .gen_call(gen_call), .addr_hit(addr_hit)
    );

    assign scl_hold = !pend_n;
endmodule

// File: rtl/ibc_checker.sv
module ibc_checker #(
    parameter int CNT_W = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             tick,
    input logic             ack_fall,
    input logic             arb_lost,
    input logic             irq_ack,
    input logic             sw_wr,
    input logic             sw_release,
    input logic             sw_irq_clr,
    input logic             pend_n,
    input logic             irq,
    input logic [CNT_W-1:0] bit_cnt,
    input logic             mst,
    input logic             gen_call
);
    AST_ACK_PEND: assert property (@(posedge clk) disable iff (rst)
        ack_fall |=> !pend_n);                                           // R1
    AST_PEND_REL: assert property (@(posedge clk) disable iff (rst)
        $rose(pend_n) |-> $past(sw_wr && sw_release));                   // R1
    AST_ACK_IRQ: assert property (@(posedge clk) disable iff (rst)
        ack_fall |=> irq);                                               // R2
    AST_IRQ_CLR: assert property (@(posedge clk) disable iff (rst)
        $fell(irq) |-> $past(irq_ack || sw_irq_clr));                    // R2
    AST_CNT_ZERO: assert property (@(posedge clk) disable iff (rst)
        ack_fall |=> (bit_cnt == '0));                                   // R4
    AST_ARB_DROP: assert property (@(posedge clk) disable iff (rst)
        arb_lost |=> !mst);                                              // R5
    AST_GC_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        $rose(gen_call) |-> $past(tick && !ack_fall));                   // R8
endmodule

bind i2c_bytedone_ctl ibc_checker #(.CNT_W(CNT_W)) u_ibc_checker (
    .clk(clk), .rst(rst), .tick(tick), .ack_fall(ack_fall),
    .arb_lost(arb_lost), .irq_ack(irq_ack), .sw_wr(sw_wr),
    .sw_release(sw_release), .sw_irq_clr(sw_irq_clr), .pend_n(pend_n),
    .irq(irq), .bit_cnt(bit_cnt), .mst(mst), .gen_call(gen_call)
);

// File: tb/i2c_bytedone_ctl_bench.sv
`timescale 1ns/1ps
module i2c_bytedone_ctl_bench;
    logic clk = 1'b0;
    logic rst, tick, bit_fall, ack_fall, addr_phase, own_match, gcall_det;
    logic rw_bit, ack_level, arb_lost, irq_ack, sw_wr, sw_release, sw_mst;
    logic sw_trx, sw_irq_clr;
    logic pend_n, irq, mst, trx, gen_call, addr_hit, scl_hold;
    logic [2:0] bit_cnt;
    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    i2c_bytedone_ctl u_i2c_bytedone_ctl (
        .clk(clk), .rst(rst), .tick(tick), .bit_fall(bit_fall), .ack_fall(ack_fall),
        .addr_phase(addr_phase), .own_match(own_match), .gcall_det(gcall_det),
        .rw_bit(rw_bit), .ack_level(ack_level), .arb_lost(arb_lost),
        .irq_ack(irq_ack), .sw_wr(sw_wr), .sw_release(sw_release),
        .sw_mst(sw_mst), .sw_trx(sw_trx), .sw_irq_clr(sw_irq_clr),
        .pend_n(pend_n), .irq(irq), .bit_cnt(bit_cnt), .mst(mst), .trx(trx),
        .gen_call(gen_call), .addr_hit(addr_hit), .scl_hold(scl_hold)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic quiet();
        tick = 0; bit_fall = 0; ack_fall = 0; addr_phase = 0; own_match = 0;
        gcall_det = 0; rw_bit = 0; ack_level = 0; arb_lost = 0; irq_ack = 0;
        sw_wr = 0; sw_release = 0; sw_mst = 0; sw_trx = 0; sw_irq_clr = 0;
    endtask

    // advance one edge, inputs then return to quiet
    task automatic step();
        @(posedge clk); #1;
        quiet();
    endtask

    task automatic sw_load(input logic m, input logic t);
        sw_wr = 1; sw_release = 1; sw_mst = m; sw_trx = t; sw_irq_clr = 1;
        step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        quiet();
        rst = 1;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        // R11 reset values
        chk("R11 pend_n", pend_n, 1);
        chk("R11 irq", irq, 0);
        chk("R11 bit_cnt", bit_cnt, 0);
        chk("R11 flags", {mst, trx, gen_call, addr_hit, scl_hold}, 0);

        // R4 counter sweep
        for (int i = 1; i <= 20; i++) begin
            bit_fall = 1; step();
            chk("R4 count", bit_cnt, i % 8);
        end
        bit_fall = 1; ack_fall = 1; step();
        chk("R4 clear priority", bit_cnt, 0);
        chk("R1 pend after ack", pend_n, 0);
        chk("R3 hold while pending", scl_hold, 1);
        chk("R2 irq set", irq, 1);
        sw_wr = 1; sw_release = 1; step();
        chk("R1 release", pend_n, 1);
        chk("R3 hold released", scl_hold, 0);
        irq_ack = 1; step();
        chk("R2 irq ack clear", irq, 0);

        // R1/R2 priority over same-cycle release and clear
        ack_fall = 1; sw_wr = 1; sw_release = 1; irq_ack = 1; sw_irq_clr = 1; step();
        chk("R1 ack beats release", pend_n, 0);
        chk("R2 set beats clear", irq, 1);
        sw_irq_clr = 1; step();
        chk("R2 sw clear", irq, 0);
        chk("R1 no release without write", pend_n, 0);
        sw_load(0, 0);

        // R10 software load
        sw_wr = 1; sw_mst = 1; sw_trx = 1; step();
        chk("R10 mst load", mst, 1);
        chk("R10 trx load", trx, 1);
        // R5 arbitration loss beats write
        arb_lost = 1; sw_wr = 1; sw_mst = 1; sw_trx = 1; step();
        chk("R5 arb clears mst", mst, 0);

        // R6 sweep of mode and ack level on data bytes
        for (int v = 0; v < 8; v++) begin
            sw_load(v[2], v[1]);
            ack_fall = 1; ack_level = v[0]; step();
            chk("R6 trx after data", trx, (v[1] && !(!v[2] && v[0])) ? 1 : 0);
            chk("R6 mst kept", mst, v[2]);
        end

        // R7/R8/R9/R12 sweep over match, general call, rw
        for (int v = 0; v < 8; v++) begin
            automatic int om = v[2], gc = v[1], rw = v[0];
            automatic int hit = om | gc;
            sw_load(0, 0);
            ack_fall = 1; addr_phase = 1; own_match = om[0]; gcall_det = gc[0];
            rw_bit = rw[0]; tick = 1; step();
            chk("R7 addr_hit", addr_hit, hit);
            chk("R12 gc not at strobe", gen_call, 0);
            step();
            chk("R8 gc waits for tick", gen_call, 0);
            tick = 1; step();
            chk("R8 gc at first tick", gen_call, gc);
            chk("R9 trx not at first tick", trx, 0);
            step();
            chk("R9 trx waits", trx, 0);
            tick = 1; step();
            chk("R9 trx at second tick", trx, hit & rw);
            chk("R7 addr_hit held", addr_hit, hit);
        end

        // R12 restart of count, R7 clears gen_call on new address
        sw_load(0, 0);
        ack_fall = 1; addr_phase = 1; gcall_det = 1; rw_bit = 1; step();
        tick = 1; step();
        chk("R8 gc set before restart", gen_call, 1);
        ack_fall = 1; addr_phase = 1; own_match = 1; rw_bit = 1; step();
        chk("R7 gc cleared by new address", gen_call, 0);
        tick = 1; step();
        chk("R12 restart trx after one tick", trx, 0);
        chk("R12 gc from new byte", gen_call, 0);
        tick = 1; step();
        chk("R12 restart trx after two ticks", trx, 1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule